// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and reduces them to a single interrupt level presented to a processor core. A low-to-high change on a request line sets a latched request bit. Software can also raise a request directly through a second register. Each line has an enable bit and a one-bit priority class. The controller always presents the highest-numbered enabled request from the upper class. When the upper class has nothing enabled and waiting, it presents the highest-numbered enabled request from the lower class. Alongside the level it gives an 8-bit trap code.

The core services an interrupt by sending a one-cycle acknowledge strobe that carries the level it took. That strobe retires the matching request. If a software-raised bit exists for that number, the strobe clears only that bit and leaves the latched hardware bit alone. Four word registers sit on a simple synchronous register bus: latched requests, enable/class, software-raised requests, and a write-one-to-clear port for the latched requests.

The reset input is asynchronous and active low. The block releases it internally through a two-stage synchronizer, so the reset state holds for two clock edges after the input rises.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable field reads as zero, `irq_level` is 0 and `irq_trap` is 8'h00, whatever requests exist.
- R2: A line's latched request bit is set on the clock edge that first samples the line high after sampling it low. A line held high does not set the bit again after the bit is cleared.
- R3: A request whose enable bit is 0 is never presented on `irq_level`, but its latched bit is still recorded and readable.
- R4: A request whose class bit is 1 is presented before any class-0 request. Within the chosen class the highest line number wins.
- R5: `irq_trap` equals 8'h10 plus `irq_level` when the level is nonzero, and 8'h00 when the level is 0.
- R6: An acknowledge for level n, when software-raised bit n is 0, clears latched bit n on that clock edge.
- R7: A software-raised bit counts as a request like a latched bit. An acknowledge for level n, when software-raised bit n is 1, clears that bit and leaves latched bit n unchanged.
- R8: Writing to address 3 clears every latched bit whose data bit is 1. If a rising edge on the same line arrives in that cycle, the bit stays set.
- R9: At address 1, bits 15:1 are the enable bits for lines 15..1 and bits 31:17 are their class bits. Writes to bits 0 and 16 are ignored, and those bits read as 0.
- R10: Address 0 reads and writes the latched requests in bits 15:1, address 2 does the same for the software-raised requests, and address 3 reads as 0. Register changes reach `irq_level` in the cycle after the updating edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 16 | Request lines; bit n is line n, bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 latched, 1 enable/class, 2 software-raised, 3 clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| ack_valid | input | 1 | One-cycle acknowledge strobe from the core |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Presented interrupt level, 0 = none |
| irq_trap | output | 8 | Trap code for the presented level |

## Verification
A corrupt latched or software-raised bit shows up on `irq_level` one cycle after the edge that corrupts it, provided that line is enabled and no higher-ranked request hides it. A hidden error surfaces on a later acknowledge, or on a read of address 0 or 2. A wrong class or enable bit shows only once a competing request from the other class is present, so the stimulus keeps several lines active in both classes at the same time. An acknowledge that retires the wrong bit leaves a stale level on the very next cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLINE = 15;
  localparam int LVLW  = $clog2(NLINE + 1);
  localparam int DATAW = 32;
  localparam int HALF  = DATAW / 2;
  localparam int TRAPW = 8;
  localparam logic [TRAPW-1:0] TRAP_BASE = 8'h10;

  typedef logic [NLINE:0] line_vec_t;

  typedef enum logic [1:0] {
    REG_LATCH = 2'd0,
    REG_ENCLS = 2'd1,
    REG_SOFT  = 2'd2,
    REG_CLR   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t src,
  output line_vec_t rise
);
  assign rise[0] = 1'b0;

  for (genvar i = 1; i <= NLINE; i++) begin : g_line
    logic src_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src[i];
    end
    assign rise[i] = src[i] & ~src_q;
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DATAW-1:0] bus_wdata,
  output logic [DATAW-1:0] bus_rdata,
  input  line_vec_t        rise,
  input  logic             ack_valid,
  input  logic [LVLW-1:0]  ack_level,
  output line_vec_t        latch_q,
  output line_vec_t        soft_q,
  output line_vec_t        en_q,
  output line_vec_t        cls_q
);
  logic      bus_wr, wr_latch, wr_encls, wr_soft, wr_clr, ack_hit;
  logic      latch_en, soft_en, encls_en;
  line_vec_t latch_n, soft_n, en_n, cls_n;

  assign bus_wr   = bus_sel & bus_we;
  assign wr_latch = bus_wr & (bus_addr == REG_LATCH);
  assign wr_encls = bus_wr & (bus_addr == REG_ENCLS);
  assign wr_soft  = bus_wr & (bus_addr == REG_SOFT);
  assign wr_clr   = bus_wr & (bus_addr == REG_CLR);
  assign ack_hit  = ack_valid & (ack_level != '0);

  assign latch_en = wr_latch | wr_clr | ack_hit | (|rise);
  assign soft_en  = wr_soft | ack_hit;
  assign encls_en = wr_encls;

  // next-state
  always_comb begin
    latch_n = latch_q;
    soft_n  = soft_q;
    en_n    = en_q;
    cls_n   = cls_q;
    if (wr_latch) latch_n = bus_wdata[NLINE:0];
    if (wr_clr)   latch_n = latch_n & ~bus_wdata[NLINE:0];
    if (wr_soft)  soft_n  = bus_wdata[NLINE:0];
    if (wr_encls) begin
      en_n  = bus_wdata[NLINE:0];
      cls_n = bus_wdata[HALF+NLINE:HALF];
    end
    if (ack_hit) begin
      if (soft_q[ack_level]) soft_n[ack_level]  = 1'b0;
      else                   latch_n[ack_level] = 1'b0;
    end
    latch_n    = latch_n | rise;
    latch_n[0] = 1'b0;
    soft_n[0]  = 1'b0;
    en_n[0]    = 1'b0;
    cls_n[0]   = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      soft_q  <= '0;
      en_q    <= '0;
      cls_q   <= '0;
    end else begin
      if (latch_en) latch_q <= latch_n;
      if (soft_en)  soft_q  <= soft_n;
      if (encls_en) begin
        en_q  <= en_n;
        cls_q <= cls_n;
      end
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (reg_sel_e'(bus_addr))
        REG_LATCH: bus_rdata[NLINE:0] = latch_q;
        REG_ENCLS: begin
          bus_rdata[NLINE:0]           = en_q;
          bus_rdata[HALF+NLINE:HALF]   = cls_q;
        end
        REG_SOFT:  bus_rdata[NLINE:0] = soft_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((latch_q & $past(rise)) == $past(rise))); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !soft_q[ack_level] && !rise[ack_level] && !bus_wr)
    |=> !latch_q[$past(ack_level)]); // R6

  AST_ACK_SOFT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && soft_q[ack_level] && !rise[ack_level] && !bus_wr)
    |=> (!soft_q[$past(ack_level)] &&
         latch_q[$past(ack_level)] == $past(latch_q[ack_level]))); // R7

  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0)); // R1
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  line_vec_t        latch_q,
  input  line_vec_t        soft_q,
  input  line_vec_t        en_q,
  input  line_vec_t        cls_q,
  output logic [LVLW-1:0]  level,
  output logic [TRAPW-1:0] trap
);
  line_vec_t req, req_hi, cand;

  assign req    = (latch_q | soft_q) & en_q;
  assign req_hi = req & cls_q;
  assign cand   = (|req_hi) ? req_hi : req;

  always_comb begin
    level = '0;
    for (int i = 1; i <= NLINE; i++) begin
      if (cand[i]) level = LVLW'(i);
    end
  end

  assign trap = (level == '0) ? '0 : (TRAP_BASE + TRAPW'(level));

  AST_MASKED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |-> en_q[level]); // R3

  AST_UPPER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_hi) |-> cls_q[level]); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (level == '0 && trap == '0)); // R5
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE:0]   irq_src,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DATAW-1:0] bus_wdata,
  output logic [DATAW-1:0] bus_rdata,
  input  logic             ack_valid,
  input  logic [LVLW-1:0]  ack_level,
  output logic [LVLW-1:0]  irq_level,
  output logic [TRAPW-1:0] irq_trap
);
  logic [1:0] rst_sync_q;
  logic       rst_s;
  line_vec_t  rise, latch_q, soft_q, en_q, cls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  irq_edge_capture u_edge (
    .clk  (clk),
    .rst_n(rst_s),
    .src  (irq_src),
    .rise (rise)
  );

  irq_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .rise     (rise),
    .ack_valid(ack_valid),
    .ack_level(ack_level),
    .latch_q  (latch_q),
    .soft_q   (soft_q),
    .en_q     (en_q),
    .cls_q    (cls_q)
  );

  irq_prio_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_s),
    .latch_q(latch_q),
    .soft_q (soft_q),
    .en_q   (en_q),
    .cls_q  (cls_q),
    .level  (irq_level),
    .trap   (irq_trap)
  );
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_src;
  logic        bus_sel, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ack_valid;
  logic [3:0]  ack_level, irq_level;
  logic [7:0]  irq_trap;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_latch, m_soft, m_en, m_cls, m_src_q;

  always #2 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_valid(ack_valid), .ack_level(ack_level),
    .irq_level(irq_level), .irq_trap(irq_trap)
  );

  function automatic int exp_level();
    logic [15:0] r = (m_latch | m_soft) & m_en;
    logic [15:0] c = ((r & m_cls) != 0) ? (r & m_cls) : r;
    for (int i = 15; i >= 1; i--) if (c[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {16'h0, m_latch};
      2'd1: return {m_cls, m_en};
      2'd2: return {16'h0, m_soft};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [15:0] rise = irq_src & ~m_src_q & 16'hFFFE;
    logic [15:0] ln = m_latch, sn = m_soft, en = m_en, cn = m_cls;
    m_src_q = irq_src;
    if (bus_sel && bus_we) begin
      case (bus_addr)
        2'd0: ln = bus_wdata[15:0];
        2'd1: begin en = bus_wdata[15:0]; cn = bus_wdata[31:16]; end
        2'd2: sn = bus_wdata[15:0];
        default: ln = ln & ~bus_wdata[15:0];
      endcase
    end
    if (ack_valid && ack_level != 0) begin
      if (m_soft[ack_level]) sn[ack_level] = 1'b0;
      else                   ln[ack_level] = 1'b0;
    end
    ln = ln | rise;
    m_latch = ln & 16'hFFFE; m_soft = sn & 16'hFFFE;
    m_en = en & 16'hFFFE;    m_cls = cn & 16'hFFFE;
  endtask

  // advance one edge, then check outputs at the following negedge
  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    bus_sel = 0; bus_we = 0; ack_valid = 0; ack_level = 0;
    #0.5;
    chk({tag, " level"}, 32'(irq_level), 32'(exp_level()));
    chk({"R5 trap"}, 32'(irq_trap),
        exp_level() == 0 ? 32'h0 : 32'h10 + 32'(exp_level()));
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick(tag);
  endtask

  task automatic rd(logic [1:0] a, string tag);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp_read(a));
    tick(tag);
  endtask

  task automatic ack(logic [3:0] l, string tag);
    ack_valid = 1; ack_level = l;
    tick(tag);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; irq_src = 0; bus_sel = 0; bus_we = 0; bus_addr = 0;
    bus_wdata = 0; ack_valid = 0; ack_level = 0;
    m_latch = 0; m_soft = 0; m_en = 0; m_cls = 0; m_src_q = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    // R1: reset state, a rising line latched but not presented
    irq_src[4] = 1;
    tick("R1 reset masked");
    rd(2'd1, "R1 enable field zero");
    rd(2'd0, "R3 masked still latched");
    irq_src[4] = 0;
    // R9: field layout, reserved bits
    wr(2'd1, 32'hFFFF_FFFF, "R9 write all");
    rd(2'd1, "R9 readback");
    wr(2'd1, 32'h0001_0001, "R9 reserved only");
    rd(2'd1, "R9 reserved ignored");
    wr(2'd1, 32'h0000_FFFE, "R3 enable all class0");
    wr(2'd0, 32'h0, "R10 latched write");
    // R2/R5 edge capture
    irq_src[5] = 1;
    tick("R2 rise latched");
    rd(2'd0, "R10 latched read");
    // R8 clear while held high: no re-latch
    wr(2'd3, 32'h0000_0020, "R2 held no relatch");
    rd(2'd3, "R10 clear reads zero");
    irq_src[5] = 0;
    tick("R2 low");
    // R8 race: clear and new edge in same cycle
    irq_src[5] = 1;
    wr(2'd3, 32'h0000_0020, "R8 edge wins");
    rd(2'd0, "R8 race readback");
    // R4 priority classes
    irq_src[12] = 1;
    tick("R4 higher number wins");
    wr(2'd1, 32'h0020_FFFE, "R4 class1 beats class0");
    wr(2'd1, 32'h1020_FFFE, "R4 highest in class1");
    // R6 ack clears latched
    ack(4'd12, "R6 ack clears latched");
    rd(2'd0, "R6 latched readback");
    // R7 soft-raised
    wr(2'd1, 32'h0000_FFFE, "R7 all class0");
    irq_src[9] = 0;
    wr(2'd2, 32'h0000_0200, "R7 soft raises 9");
    irq_src[9] = 1;
    tick("R7 latch 9 too");
    ack(4'd9, "R7 ack clears soft first");
    rd(2'd2, "R7 soft readback");
    rd(2'd0, "R7 latched kept");
    ack(4'd9, "R6 second ack clears latched");
    // R3 disable everything
    wr(2'd1, 32'h0, "R3 all disabled");
    rd(2'd0, "R3 latched visible");
    // random phase
    wr(2'd1, 32'hA5A0_FFFE, "R4 random setup");
    for (int k = 0; k < 4000; k++) begin
      int op = $urandom % 16;
      if (($urandom % 4) == 0) irq_src = irq_src ^ 16'($urandom & $urandom);
      case (op)
        0: wr(2'd0, $urandom & $urandom, "R10 rnd latched");
        1: wr(2'd1, $urandom, "R9 rnd encls");
        2: wr(2'd2, $urandom & $urandom & $urandom, "R7 rnd soft");
        3: wr(2'd3, $urandom, "R8 rnd clear");
        4, 5: rd(2'($urandom), "R10 rnd read");
        default: begin
          if (exp_level() != 0 && ($urandom % 2) == 1)
            ack(4'(exp_level()), "R6 rnd ack");
          else
            tick("R4 rnd idle");
        end
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule